// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Unit with Selectable Fill

This block is a purely combinational slice of an 8-bit data path that moves one operand byte by a single bit position, left or right, and produces the next CARRY and ZERO flags. A 4-bit operation code, taken from the low bits of an instruction word, selects the direction and the source of the bit that enters the vacated end. That bit can be a constant 0, a constant 1, a copy of an edge bit of the operand (which gives rotation or sign extension, depending on direction), or the incoming CARRY flag.

The bit that falls off the far end always becomes the next CARRY. ZERO reports whether the produced byte is all zeros. A code outside the ten defined ones leaves the byte and CARRY as they were and raises an invalid-operation output. The surrounding datapath uses that output to skip the flag write. There is no clock and no storage: the outputs follow the inputs within the same cycle, and the register file and flag registers that consume them lie outside this block.

Top module: `shift_rot_unit`

## Requirements
- R1: The ten valid codes are 0010, 1100, 0110, 0111, 0100, 0000, 1110, 1111, 1010 and 1000 (op_code[3:0]). For each of them op_bad is 0. op_code[3]=0 selects a left move and op_code[3]=1 selects a right move.
- R2: For a valid left code, carry_out equals data_in[7] and data_out[7:1] equals data_in[6:0].
- R3: For a valid right code, carry_out equals data_in[0] and data_out[6:0] equals data_in[7:1].
- R4: Rotate left (0010) puts the old data_in[7] into data_out[0]. Rotate right (1100) puts the old data_in[0] into data_out[7].
- R5: The left shifts fill data_out[0] as follows: 0110 fills with 0, 0111 with 1, 0100 with the old data_in[0], and 0000 with carry_in.
- R6: The right shifts fill data_out[7] as follows: 1110 fills with 0, 1111 with 1, 1010 with the old data_in[7], and 1000 with carry_in.
- R7: For a valid code, zero_out is 1 exactly when data_out is 0x00. As a result, 0111 and 1111 never raise zero_out.
- R8: For any of the six other codes (low three bits 001, 011 or 101), op_bad is 1, data_out equals data_in, carry_out equals carry_in and zero_out is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 8 | Operand byte |
| carry_in | input | 1 | Current CARRY flag |
| op_code | input | 4 | Operation select, low instruction bits |
| data_out | output | 8 | Shifted or rotated byte |
| carry_out | output | 1 | Next CARRY (bit moved out) |
| zero_out | output | 1 | Next ZERO (result is all zeros) |
| op_bad | output | 1 | Code is not one of the ten defined operations |

## Verification
The bench applies all 16 codes against every byte value with carry_in both 0 and 1. This finds a swapped fill source (for example, extend copying the wrong edge bit, or a rotate taking the incoming CARRY), which would corrupt only the end bit of the result for half of the inputs. It targets the bytes 0x80 and 0x01, where a one-position slip makes the result zero: a ZERO flag computed from the input instead of the result would then miss, and a constant-1 fill that leaked a zero would wrongly raise it. The six undefined codes are checked for pass-through of both byte and CARRY, so a decoder that treats them as neighbours of a real operation is caught. Seeded random vectors and a few directed corner cases are mixed with the exhaustive sweep.

// File: rtl/shift_rot_pkg.sv
package shift_rot_pkg;

  localparam int OP_W = 4;

  // Source of the bit entering the vacated end
  typedef enum logic [1:0] {
    FILL_CARRY  = 2'd0,
    FILL_TOP    = 2'd1,
    FILL_BOTTOM = 2'd2,
    FILL_CONST  = 2'd3
  } fill_src_e;

  typedef struct packed {
    logic      go_right;
    fill_src_e src;
    logic      const_val;
    logic      bad;
  } op_ctrl_t;

endpackage

// File: rtl/shift_rot_decode.sv
module shift_rot_decode
  import shift_rot_pkg::*;
(
  input  logic [OP_W-1:0] op_code,
  output op_ctrl_t        ctrl
);

  // The fill selection in the low bits does not depend on direction:
  // 010 always copies the top bit (rotate left / sign extend right),
  // 100 always copies the bottom bit (extend left / rotate right).
  always_comb begin
    ctrl.go_right  = op_code[OP_W-1];
    ctrl.src       = FILL_CARRY;
    ctrl.const_val = 1'b0;
    ctrl.bad       = 1'b0;
    unique case (op_code[OP_W-2:0])
      3'b000: ctrl.src = FILL_CARRY;
      3'b010: ctrl.src = FILL_TOP;
      3'b100: ctrl.src = FILL_BOTTOM;
      3'b110: begin
        ctrl.src       = FILL_CONST;
        ctrl.const_val = 1'b0;
      end
      3'b111: begin
        ctrl.src       = FILL_CONST;
        ctrl.const_val = 1'b1;
      end
      default: ctrl.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/shift_rot_fill.sv
module shift_rot_fill
  import shift_rot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              carry_i,
  input  fill_src_e         src,
  input  logic              const_val,
  output logic              fill_o
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    unique case (src)
      FILL_CARRY:  fill_o = carry_i;
      FILL_TOP:    fill_o = data_i[MSB];
      FILL_BOTTOM: fill_o = data_i[0];
      default:     fill_o = const_val;
    endcase
  end

endmodule

// File: rtl/shift_rot_core.sv
module shift_rot_core #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              go_right,
  input  logic              fill_i,
  output logic [DATA_W-1:0] data_o,
  output logic              out_bit_o
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] left_v;
  logic [DATA_W-1:0] right_v;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    if (i == 0) begin : g_low
      assign left_v[i]  = fill_i;
      assign right_v[i] = data_i[i+1];
    end else if (i == MSB) begin : g_high
      assign left_v[i]  = data_i[i-1];
      assign right_v[i] = fill_i;
    end else begin : g_mid
      assign left_v[i]  = data_i[i-1];
      assign right_v[i] = data_i[i+1];
    end
  end

  assign data_o    = go_right ? right_v : left_v;
  assign out_bit_o = go_right ? data_i[0] : data_i[MSB];

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shift_rot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic              carry_in,
  input  logic [OP_W-1:0]   op_code,
  output logic [DATA_W-1:0] data_out,
  output logic              carry_out,
  output logic              zero_out,
  output logic              op_bad
);

  op_ctrl_t          ctrl;
  logic              fill_bit;
  logic [DATA_W-1:0] moved;
  logic              moved_out;

  shift_rot_decode u_decode (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  shift_rot_fill #(.DATA_W(DATA_W)) u_fill (
    .data_i    (data_in),
    .carry_i   (carry_in),
    .src       (ctrl.src),
    .const_val (ctrl.const_val),
    .fill_o    (fill_bit)
  );

  shift_rot_core #(.DATA_W(DATA_W)) u_core (
    .data_i    (data_in),
    .go_right  (ctrl.go_right),
    .fill_i    (fill_bit),
    .data_o    (moved),
    .out_bit_o (moved_out)
  );

  // Undefined codes pass the operand and carry through untouched
  always_comb begin
    op_bad = ctrl.bad;
    if (ctrl.bad) begin
      data_out  = data_in;
      carry_out = carry_in;
      zero_out  = 1'b0;
    end else begin
      data_out  = moved;
      carry_out = moved_out;
      zero_out  = ~|moved;
    end
  end

endmodule

// File: rtl/shift_rot_unit_chk.sv
module shift_rot_unit_chk
  import shift_rot_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] data_in,
  input logic              carry_in,
  input logic [OP_W-1:0]   op_code,
  input logic [DATA_W-1:0] data_out,
  input logic              carry_out,
  input logic              zero_out,
  input logic              op_bad
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    if (!op_bad && !op_code[OP_W-1]) begin
      p_left_move_r2: assert (carry_out == data_in[MSB] &&
                              data_out[MSB:1] == data_in[MSB-1:0]);
    end
    if (!op_bad && op_code[OP_W-1]) begin
      p_right_move_r3: assert (carry_out == data_in[0] &&
                               data_out[MSB-1:0] == data_in[MSB:1]);
    end
    if (op_code == 4'b0010) begin
      p_rot_left_r4: assert (data_out[0] == data_in[MSB] && !op_bad);
    end
    if (op_code == 4'b1100) begin
      p_rot_right_r4: assert (data_out[MSB] == data_in[0] && !op_bad);
    end
    if (!op_bad) begin
      p_zero_flag_r7: assert (zero_out == (data_out == '0));
    end
    if (op_code[OP_W-2:0] == 3'b111) begin
      p_one_fill_nonzero_r7: assert (!zero_out);
    end
    if (op_bad) begin
      p_bad_pass_r8: assert (data_out == data_in && carry_out == carry_in &&
                             !zero_out);
    end
    if (op_code[0] == 1'b0) begin
      p_even_code_valid_r1: assert (!op_bad);
    end
  end

endmodule

bind shift_rot_unit shift_rot_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/shift_rot_unit_tb_top.sv
`timescale 1ns/1ps
module shift_rot_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in  = 8'h00;
  logic       carry_in = 1'b0;
  logic [3:0] op_code  = 4'b0000;
  logic [7:0] data_out;
  logic       carry_out;
  logic       zero_out;
  logic       op_bad;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  shift_rot_unit dut_i (
    .data_in   (data_in),
    .carry_in  (carry_in),
    .op_code   (op_code),
    .data_out  (data_out),
    .carry_out (carry_out),
    .zero_out  (zero_out),
    .op_bad    (op_bad)
  );

  // Reference from the requirements: {bad, zero, carry, byte}
  function automatic logic [10:0] model(logic [7:0] d, logic c, logic [3:0] op);
    logic [7:0] r;
    logic       nc;
    logic       bad;
    bad = 1'b0;
    case (op)
      4'b0010: begin r = {d[6:0], d[7]}; nc = d[7]; end // R4 rotate left
      4'b1100: begin r = {d[0], d[7:1]}; nc = d[0]; end // R4 rotate right
      4'b0110: begin r = {d[6:0], 1'b0}; nc = d[7]; end // R5
      4'b0111: begin r = {d[6:0], 1'b1}; nc = d[7]; end // R5
      4'b0100: begin r = {d[6:0], d[0]}; nc = d[7]; end // R5
      4'b0000: begin r = {d[6:0], c};    nc = d[7]; end // R5
      4'b1110: begin r = {1'b0, d[7:1]}; nc = d[0]; end // R6
      4'b1111: begin r = {1'b1, d[7:1]}; nc = d[0]; end // R6
      4'b1010: begin r = {d[7], d[7:1]}; nc = d[0]; end // R6
      4'b1000: begin r = {c, d[7:1]};    nc = d[0]; end // R6
      default: begin r = d; nc = c; bad = 1'b1; end     // R8
    endcase
    return {bad, (!bad && r == 8'h00), nc, r};
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: op=%b in=%02h cin=%0d got %0h expected %0h",
               tag, what, op_code, data_in, carry_in, act, exp);
    end
  endtask

  task automatic apply(logic [7:0] d, logic c, logic [3:0] op);
    logic [10:0] e;
    string data_tag;
    string carry_tag;
    @(posedge clk);
    data_in  <= d;
    carry_in <= c;
    op_code  <= op;
    @(negedge clk);
    e = model(d, c, op);
    if (e[10])                        data_tag = "R8";
    else if (op == 4'b0010 || op == 4'b1100) data_tag = "R4";
    else if (!op[3])                  data_tag = "R5";
    else                              data_tag = "R6";
    if (e[10])      carry_tag = "R8";
    else if (!op[3]) carry_tag = "R2";
    else            carry_tag = "R3";
    check(data_tag,  "data_out",  int'(data_out),  int'(e[7:0]));
    check(carry_tag, "carry_out", int'(carry_out), int'(e[8]));
    check(e[10] ? "R8" : "R7", "zero_out", int'(zero_out), int'(e[9]));
    check(e[10] ? "R8" : "R1", "op_bad", int'(op_bad), int'(e[10]));
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    // Idle state after reset: all-zero inputs select carry-fill shift left
    check("R1", "reset op_bad", int'(op_bad), 0);
    check("R7", "reset zero_out", int'(zero_out), 1);

    // Directed corners
    apply(8'h80, 1'b0, 4'b0110); // R2 bit 7 leaves, result zero
    apply(8'h00, 1'b0, 4'b0111); // R7 one fill never zero
    apply(8'h01, 1'b0, 4'b1110); // R3 bit 0 leaves, result zero
    apply(8'h00, 1'b0, 4'b1111); // R7
    apply(8'h80, 1'b0, 4'b1010); // R6 sign extend
    apply(8'h01, 1'b1, 4'b0100); // R5 extend low bit
    apply(8'h00, 1'b1, 4'b0000); // R5 carry in
    apply(8'h00, 1'b1, 4'b1000); // R6 carry in
    apply(8'h00, 1'b1, 4'b1011); // R8 invalid keeps carry
    apply(8'h5A, 1'b0, 4'b0101); // R8

    // Exhaustive sweep over codes, bytes and carry
    for (int op = 0; op < 16; op++)
      for (int d = 0; d < 256; d++)
        for (int c = 0; c < 2; c++)
          apply(8'(d), 1'(c), 4'(op));

    // Seeded random mix
    for (int k = 0; k < 2000; k++)
      apply(8'($urandom), 1'($urandom), 4'($urandom));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule